// File: doc/BRIEF.md
# Vectored interrupt priority core

This block sits between interrupt sources and one CPU. It holds one bit per vector in three registers: a pending set, an in-service set and a trigger-type set. A request names a vector and says whether it is level or edge triggered. Each cycle the block finds the highest pending vector and compares its priority class with a processor priority. The processor priority is formed from a software task priority and from the highest vector now in service. The result drives a registered interrupt line to the CPU.

The CPU takes an interrupt by pulsing an acknowledge. One cycle later the block reports one of three results. It can return a vector, which then moves from pending to in-service. It can return the spurious vector when something is pending but is masked. It can report "none" when nothing may be taken. An end-of-interrupt pulse retires the highest in-service vector. When that vector was level triggered, the block also emits a broadcast pulse that carries the vector, unless software has suppressed broadcasts.

The priority class is the upper bits of a vector; by default these are the upper four of eight. Vector count, class width and the search structure are parameters.

Top module: `vec_prio_core`

## Requirements
- R1: After reset the pending, in-service and trigger sets are empty, the task priority and the control word are zero (so delivery is disabled), and `irq`, `ack_done`, `eoi_bcast` and `ppr` are all 0.
- R2: A request sets the pending bit of `req_vec`. With delivery enabled and nothing masking it, `irq` then rises.
- R3: Among pending vectors, the highest-numbered one is always the candidate that is offered and acknowledged first.
- R4: `ppr` equals the task priority when the task priority's class (bits 7:4) is at least the class of the highest in-service vector. Otherwise it equals that in-service vector with bits 3:0 cleared. An empty in-service set counts as vector 0.
- R5: A pending vector is masked when `ppr` is nonzero and the vector's class is less than or equal to the class of `ppr`. A masked candidate keeps `irq` low.
- R6: An acknowledge that meets a deliverable candidate returns it on `ack_vec` with `ack_done` high and both flags low. It clears that vector's pending bit and sets its in-service bit.
- R7: An acknowledge while a candidate is pending but masked returns control-word bits 7:0 with `ack_spurious` high, and changes no state.
- R8: An acknowledge with nothing pending, or with delivery disabled, gives `ack_none` high and `ack_vec` 0, and changes no state.
- R9: An end-of-interrupt clears only the highest in-service bit. With nothing in service it has no effect.
- R10: When the retired vector's trigger bit is set (level), `eoi_bcast` pulses for one cycle with `eoi_bcast_vec` equal to that vector.
- R11: A level request sets the vector's trigger bit and an edge request clears it, so a later end-of-interrupt for that vector broadcasts or stays silent to match.
- R12: With control-word bit 9 (broadcast suppress) set, no end-of-interrupt broadcasts.
- R13: With control-word bit 8 (delivery enable) clear, `irq` stays low.
- R14: `irq` reflects the state one clock edge after that state is updated. Acknowledge and end-of-interrupt results appear one edge after their request, as one-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Interrupt request strobe |
| req_vec | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level triggered, 0 = edge triggered |
| ack_req | input | 1 | CPU acknowledge pulse |
| eoi_req | input | 1 | End-of-interrupt pulse |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority value |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 10 | [7:0] spurious vector, [8] delivery enable, [9] broadcast suppress |
| irq | output | 1 | Registered interrupt line to the CPU |
| ack_done | output | 1 | Acknowledge result valid (one cycle) |
| ack_vec | output | 8 | Acknowledged or spurious vector |
| ack_spurious | output | 1 | Result is the spurious vector |
| ack_none | output | 1 | Nothing could be taken |
| eoi_bcast | output | 1 | Level end-of-interrupt broadcast pulse |
| eoi_bcast_vec | output | 8 | Vector carried by the broadcast |
| ppr | output | 8 | Current processor priority |

## Verification
A corrupted pending bit shows on `irq` within one edge. It is also unmistakable at the next acknowledge, which returns a wrong vector or the wrong kind of result. A corrupted in-service bit shows at once on `ppr`, and it changes which candidates are masked. A bad trigger bit stays hidden until the end-of-interrupt for that vector, when the broadcast pulse appears or goes missing. The sweeps therefore follow every vector through request, acknowledge and retirement.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
   localparam int CTL_W       = 10;
   localparam int CTL_EN_BIT  = 8;
   localparam int CTL_SUP_BIT = 9;

   typedef enum logic [1:0] {
      ACK_TAKEN = 2'd0,
      ACK_SPUR  = 2'd1,
      ACK_EMPTY = 2'd2
   } ack_kind_e;
endpackage

// File: rtl/vpc_hi_find.sv
module vpc_hi_find #(
   parameter int WIDTH     = 256,
   parameter int GRP       = 32,
   parameter bit TWO_LEVEL = 1'b1
) (
   input  logic [WIDTH-1:0]         bits,
   output logic                     found,
   output logic [$clog2(WIDTH)-1:0] idx
);
   localparam int IDX_W = $clog2(WIDTH);
   localparam int NGRP  = WIDTH / GRP;
   localparam int SUB_W = $clog2(GRP);

   if (WIDTH < 2 || (1 << IDX_W) != WIDTH) begin : g_bad_width
      $error("vpc_hi_find: WIDTH must be a power of two");
   end

   if (TWO_LEVEL) begin : g_two
      if (GRP < 2 || WIDTH % GRP != 0) begin : g_bad_grp
         $error("vpc_hi_find: GRP must divide WIDTH and be at least 2");
      end

      logic [NGRP-1:0]       grp_any;
      logic [NGRP*SUB_W-1:0] grp_sub;

      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         logic [GRP-1:0]   slice;
         logic [SUB_W-1:0] sub;
         assign slice = bits[g*GRP +: GRP];
         always_comb begin
            sub = '0;
            for (int b = 0; b < GRP; b++) begin
               if (slice[b]) sub = SUB_W'(b);
            end
         end
         assign grp_any[g]                 = |slice;
         assign grp_sub[g*SUB_W +: SUB_W]  = sub;
      end

      always_comb begin
         found = 1'b0;
         idx   = '0;
         for (int g = 0; g < NGRP; g++) begin
            if (grp_any[g]) begin
               found = 1'b1;
               idx   = IDX_W'(g*GRP) + IDX_W'(grp_sub[g*SUB_W +: SUB_W]);
            end
         end
      end
   end else begin : g_flat
      always_comb begin
         found = 1'b0;
         idx   = '0;
         for (int b = 0; b < WIDTH; b++) begin
            if (bits[b]) begin
               found = 1'b1;
               idx   = IDX_W'(b);
            end
         end
      end
   end
endmodule

// File: rtl/vpc_arbiter.sv
module vpc_arbiter #(
   parameter int VEC_W = 8,
   parameter int CLS_W = 4
) (
   input  logic             pend_found,
   input  logic [VEC_W-1:0] pend_vec,
   input  logic             svc_found,
   input  logic [VEC_W-1:0] svc_vec,
   input  logic [VEC_W-1:0] task_pri,
   output logic [VEC_W-1:0] proc_pri,
   output logic             deliver
);
   localparam int LO_W = VEC_W - CLS_W;

   if (CLS_W < 1 || CLS_W > VEC_W) begin : g_bad_cls
      $error("vpc_arbiter: CLS_W must be in 1..VEC_W");
   end

   logic [CLS_W-1:0] svc_cls;
   logic [CLS_W-1:0] task_cls;
   logic [CLS_W-1:0] pend_cls;
   logic             masked;

   assign svc_cls  = svc_found ? svc_vec[VEC_W-1 -: CLS_W] : '0;
   assign task_cls = task_pri[VEC_W-1 -: CLS_W];
   assign pend_cls = pend_vec[VEC_W-1 -: CLS_W];

   always_comb begin
      if (task_cls >= svc_cls) proc_pri = task_pri;
      else                     proc_pri = VEC_W'(svc_cls) << LO_W;
   end

   assign masked  = (proc_pri != '0) && (pend_cls <= proc_pri[VEC_W-1 -: CLS_W]);
   assign deliver = pend_found && !masked;
endmodule

// File: rtl/vpc_vec_bank.sv
module vpc_vec_bank #(
   parameter int VEC_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [VEC_W-1:0]      req_vec,
   input  logic                  req_level,
   input  logic                  take_en,
   input  logic [VEC_W-1:0]      take_vec,
   input  logic                  retire_en,
   input  logic [VEC_W-1:0]      retire_vec,
   output logic [(1<<VEC_W)-1:0] pend,
   output logic [(1<<VEC_W)-1:0] svc,
   output logic [(1<<VEC_W)-1:0] trig
);
   localparam int NV = 1 << VEC_W;

   logic [NV-1:0] req_mask, take_mask, retire_mask;
   logic [NV-1:0] pend_d, svc_d, trig_d;

   for (genvar i = 0; i < NV; i++) begin : g_dec
      assign req_mask[i]    = req_valid && (req_vec    == VEC_W'(i));
      assign take_mask[i]   = take_en   && (take_vec   == VEC_W'(i));
      assign retire_mask[i] = retire_en && (retire_vec == VEC_W'(i));
   end

   always_comb begin
      pend_d = (pend & ~take_mask) | req_mask;
      svc_d  = (svc & ~retire_mask) | take_mask;
      trig_d = req_level ? (trig | req_mask) : (trig & ~req_mask);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= '0;
         svc  <= '0;
         trig <= '0;
      end else begin
         pend <= pend_d;
         svc  <= svc_d;
         trig <= trig_d;
      end
   end
endmodule

// File: rtl/vec_prio_core.sv
module vec_prio_core #(
   parameter int VEC_W     = 8,
   parameter int CLS_W     = 4,
   parameter int GRP       = 32,
   parameter bit TWO_LEVEL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VEC_W-1:0] req_vec,
   input  logic             req_level,
   input  logic             ack_req,
   input  logic             eoi_req,
   input  logic             tpr_we,
   input  logic [VEC_W-1:0] tpr_wdata,
   input  logic             ctl_we,
   input  logic [VEC_W+1:0] ctl_wdata,
   output logic             irq,
   output logic             ack_done,
   output logic [VEC_W-1:0] ack_vec,
   output logic             ack_spurious,
   output logic             ack_none,
   output logic             eoi_bcast,
   output logic [VEC_W-1:0] eoi_bcast_vec,
   output logic [VEC_W-1:0] ppr
);
   import vpc_pkg::*;

   localparam int NV = 1 << VEC_W;

   if (VEC_W != CTL_EN_BIT) begin : g_bad_ctl
      $error("vec_prio_core: control word layout assumes VEC_W == 8");
   end

   logic [NV-1:0]      pend, svc, trig;
   logic               pend_found, svc_found;
   logic [VEC_W-1:0]   pend_idx, svc_idx;
   logic [VEC_W-1:0]   tpr_q;
   logic [CTL_W-1:0]   ctl_q;
   logic               sw_en, deliver;
   logic               take_en, retire_en, bcast_d;
   ack_kind_e          kind_d, kind_q;
   logic [VEC_W-1:0]   ack_vec_d;
   logic               irq_q, ack_done_q, bcast_q;
   logic [VEC_W-1:0]   ack_vec_q, bcast_vec_q;

   vpc_vec_bank #(.VEC_W(VEC_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_vec    (req_vec),
      .req_level  (req_level),
      .take_en    (take_en),
      .take_vec   (pend_idx),
      .retire_en  (retire_en),
      .retire_vec (svc_idx),
      .pend       (pend),
      .svc        (svc),
      .trig       (trig)
   );

   vpc_hi_find #(.WIDTH(NV), .GRP(GRP), .TWO_LEVEL(TWO_LEVEL)) u_find_pend (
      .bits  (pend),
      .found (pend_found),
      .idx   (pend_idx)
   );

   vpc_hi_find #(.WIDTH(NV), .GRP(GRP), .TWO_LEVEL(TWO_LEVEL)) u_find_svc (
      .bits  (svc),
      .found (svc_found),
      .idx   (svc_idx)
   );

   vpc_arbiter #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_arb (
      .pend_found (pend_found),
      .pend_vec   (pend_idx),
      .svc_found  (svc_found),
      .svc_vec    (svc_idx),
      .task_pri   (tpr_q),
      .proc_pri   (ppr),
      .deliver    (deliver)
   );

   assign sw_en     = ctl_q[CTL_EN_BIT];
   assign take_en   = ack_req && sw_en && deliver;
   assign retire_en = eoi_req && svc_found;
   assign bcast_d   = retire_en && trig[svc_idx] && !ctl_q[CTL_SUP_BIT];

   always_comb begin
      if (!sw_en || !pend_found) begin
         kind_d    = ACK_EMPTY;
         ack_vec_d = '0;
      end else if (deliver) begin
         kind_d    = ACK_TAKEN;
         ack_vec_d = pend_idx;
      end else begin
         kind_d    = ACK_SPUR;
         ack_vec_d = ctl_q[VEC_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tpr_q       <= '0;
         ctl_q       <= '0;
         irq_q       <= 1'b0;
         ack_done_q  <= 1'b0;
         kind_q      <= ACK_EMPTY;
         ack_vec_q   <= '0;
         bcast_q     <= 1'b0;
         bcast_vec_q <= '0;
      end else begin
         if (tpr_we) tpr_q <= tpr_wdata;
         if (ctl_we) ctl_q <= ctl_wdata;
         irq_q      <= sw_en && deliver;
         ack_done_q <= ack_req;
         if (ack_req) begin
            kind_q    <= kind_d;
            ack_vec_q <= ack_vec_d;
         end
         bcast_q     <= bcast_d;
         bcast_vec_q <= bcast_d ? svc_idx : '0;
      end
   end

   assign irq           = irq_q;
   assign ack_done      = ack_done_q;
   assign ack_vec       = ack_done_q ? ack_vec_q : '0;
   assign ack_spurious  = ack_done_q && (kind_q == ACK_SPUR);
   assign ack_none      = ack_done_q && (kind_q == ACK_EMPTY);
   assign eoi_bcast     = bcast_q;
   assign eoi_bcast_vec = bcast_vec_q;
endmodule

// File: rtl/vpc_core_chk.sv
module vpc_core_chk #(
   parameter int VEC_W = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  irq,
   input logic                  sw_en,
   input logic                  ack_req,
   input logic                  ack_done,
   input logic [VEC_W-1:0]      ack_vec,
   input logic                  ack_spurious,
   input logic                  ack_none,
   input logic                  eoi_req,
   input logic                  eoi_bcast,
   input logic                  req_valid,
   input logic [VEC_W-1:0]      req_vec,
   input logic [VEC_W-1:0]      ppr,
   input logic [VEC_W-1:0]      tpr_q,
   input logic [(1<<VEC_W)-1:0] pend,
   input logic [(1<<VEC_W)-1:0] svc
);
   // R14: an acknowledge result only follows an acknowledge request
   p_ack_follows_req_r14: assert property (@(posedge clk) disable iff (!rst_n)
      ack_done |-> $past(ack_req));

   // R13: the line is only raised while delivery was enabled
   p_irq_needs_enable_r13: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(sw_en));

   // R6: a taken vector is in service afterwards
   p_taken_in_service_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_done && !ack_spurious && !ack_none) |-> svc[ack_vec]);

   // R6: a taken vector leaves the pending set unless re-requested at once
   p_taken_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_done && !ack_spurious && !ack_none &&
       !$past(req_valid && (req_vec == ack_vec))) |-> !pend[ack_vec]);

   // R4: processor priority never drops below the task priority
   p_ppr_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ppr >= tpr_q);

   // R10: a broadcast only follows an end-of-interrupt request
   p_bcast_from_eoi_r10: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_bcast |-> $past(eoi_req));

   // R7: result flags are exclusive and only valid with a result
   p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_spurious || ack_none) |-> (ack_done && $countones({ack_spurious, ack_none}) == 1));
endmodule

bind vec_prio_core vpc_core_chk #(.VEC_W(VEC_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .irq          (irq),
   .sw_en        (sw_en),
   .ack_req      (ack_req),
   .ack_done     (ack_done),
   .ack_vec      (ack_vec),
   .ack_spurious (ack_spurious),
   .ack_none     (ack_none),
   .eoi_req      (eoi_req),
   .eoi_bcast    (eoi_bcast),
   .req_valid    (req_valid),
   .req_vec      (req_vec),
   .ppr          (ppr),
   .tpr_q        (tpr_q),
   .pend         (pend),
   .svc          (svc)
);

// File: tb/test_vec_prio_core.sv
module test_vec_prio_core;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       req_valid, req_level, ack_req, eoi_req, tpr_we, ctl_we;
   logic [7:0] req_vec, tpr_wdata;
   logic [9:0] ctl_wdata;
   logic       irq, ack_done, ack_spurious, ack_none, eoi_bcast;
   logic [7:0] ack_vec, eoi_bcast_vec, ppr;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [255:0] m_pend, m_svc, m_trig;
   logic [7:0]   m_tpr;
   logic [9:0]   m_ctl;

   always #2 clk = ~clk;

   vec_prio_core i_vec_prio_core (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_vec(req_vec), .req_level(req_level),
      .ack_req(ack_req), .eoi_req(eoi_req),
      .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .irq(irq), .ack_done(ack_done), .ack_vec(ack_vec),
      .ack_spurious(ack_spurious), .ack_none(ack_none),
      .eoi_bcast(eoi_bcast), .eoi_bcast_vec(eoi_bcast_vec), .ppr(ppr)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic int hi(input logic [255:0] v);
      for (int i = 255; i >= 0; i--) if (v[i]) return i;
      return -1;
   endfunction

   function automatic logic [7:0] m_ppr();
      int s = hi(m_svc);
      logic [7:0] sv;
      if (s < 0) s = 0;
      sv = 8'(s);
      if (m_tpr[7:4] >= sv[7:4]) return m_tpr;
      return {sv[7:4], 4'h0};
   endfunction

   function automatic bit m_deliv();
      int h = hi(m_pend);
      logic [7:0] hv, p;
      if (h < 0) return 1'b0;
      hv = 8'(h);
      p  = m_ppr();
      if (p != 0 && hv[7:4] <= p[7:4]) return 1'b0;
      return 1'b1;
   endfunction

   task automatic check_state(input string tag);
      check("R14", {tag, " irq"}, int'(irq), int'(m_ctl[8] && m_deliv()));
      check("R4", {tag, " ppr"}, int'(ppr), int'(m_ppr()));
   endtask

   task automatic t_req(input logic [7:0] v, input logic lvl, input string tag);
      req_valid = 1'b1; req_vec = v; req_level = lvl;
      @(negedge clk);
      req_valid = 1'b0;
      m_pend[v] = 1'b1;
      m_trig[v] = lvl;
      @(negedge clk);
      check_state(tag);
   endtask

   task automatic t_ack(input string tag);
      int h = hi(m_pend);
      int kind;
      int ev;
      if (!m_ctl[8] || h < 0) begin kind = 2; ev = 0; end
      else if (m_deliv()) begin kind = 0; ev = h; end
      else begin kind = 1; ev = int'(m_ctl[7:0]); end
      ack_req = 1'b1;
      @(negedge clk);
      ack_req = 1'b0;
      check(tag, "ack_done", int'(ack_done), 1);
      if (kind == 0) begin
         check("R6", {tag, " taken vec"}, int'(ack_vec), ev);
         check("R6", {tag, " taken flags"}, int'({ack_spurious, ack_none}), 0);
         m_pend[h] = 1'b0;
         m_svc[h]  = 1'b1;
      end else if (kind == 1) begin
         check("R7", {tag, " spurious vec"}, int'(ack_vec), ev);
         check("R7", {tag, " spurious flag"}, int'({ack_spurious, ack_none}), 2);
      end else begin
         check("R8", {tag, " none"}, int'({ack_spurious, ack_none, ack_vec}), 256);
      end
      @(negedge clk);
      check("R14", {tag, " ack pulse"}, int'(ack_done), 0);
      check_state(tag);
   endtask

   task automatic t_eoi(input string tag);
      int h = hi(m_svc);
      bit eb = (h >= 0) && m_trig[h] && !m_ctl[9];
      eoi_req = 1'b1;
      @(negedge clk);
      eoi_req = 1'b0;
      check(tag, "eoi_bcast", int'(eoi_bcast), int'(eb));
      if (eb) check("R10", {tag, " bcast vec"}, int'(eoi_bcast_vec), h);
      if (h >= 0) m_svc[h] = 1'b0;
      @(negedge clk);
      check("R14", {tag, " bcast pulse"}, int'(eoi_bcast), 0);
      check_state(tag);
   endtask

   task automatic t_tpr(input logic [7:0] v);
      tpr_we = 1'b1; tpr_wdata = v;
      @(negedge clk);
      tpr_we = 1'b0;
      m_tpr = v;
      @(negedge clk);
      check_state("R5 tpr write");
   endtask

   task automatic t_ctl(input logic [9:0] v);
      ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_we = 1'b0;
      m_ctl = v;
      @(negedge clk);
      check_state("R13 ctl write");
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      req_valid = 0; req_vec = 0; req_level = 0; ack_req = 0; eoi_req = 0;
      tpr_we = 0; tpr_wdata = 0; ctl_we = 0; ctl_wdata = 0;
      m_pend = '0; m_svc = '0; m_trig = '0; m_tpr = '0; m_ctl = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1", "reset outputs", int'({irq, ack_done, eoi_bcast}), 0);
      check("R1", "reset ppr", int'(ppr), 0);
      t_ack("R1 empty ack");
      // R13: disabled delivery keeps irq low and acks report none
      t_req(8'h60, 1'b0, "R13 disabled req");
      t_ack("R13 disabled ack");
      t_ctl(10'h1F7);
      t_ack("R2 enabled ack");
      t_eoi("R9 retire");

      // R2/R6: every vector, edge triggered, unmasked
      for (int v = 0; v < 256; v++) begin
         t_req(8'(v), 1'b0, "R2 sweep");
         t_ack("R6 sweep");
         t_eoi("R11 edge eoi");
      end

      // R5/R7: task priority class against request class
      for (int t = 0; t < 16; t++) begin
         for (int c = 0; c < 16; c++) begin
            t_tpr({4'(t), 4'h9});
            t_req({4'(c), 4'h6}, 1'b0, "R5 class");
            t_ack("R7 class ack");
            if (m_pend != '0) begin
               t_tpr(8'h00);
               t_ack("R6 after unmask");
            end
            t_eoi("R9 class eoi");
         end
      end
      t_tpr(8'h00);

      // R3/R5/R9: ordering and in-service masking
      t_req(8'h85, 1'b0, "R3 order");
      t_req(8'h31, 1'b0, "R3 order");
      t_req(8'h82, 1'b0, "R3 order");
      t_req(8'hC0, 1'b0, "R3 order");
      t_ack("R3 highest");
      t_ack("R5 masked by service");
      t_eoi("R9 top retire");
      t_ack("R3 next");
      t_ack("R5 same class");
      t_eoi("R9 retire");
      t_ack("R3 next");
      t_eoi("R9 retire");
      t_ack("R3 last");
      t_eoi("R9 retire");

      // R10: level vectors broadcast on retirement
      for (int v = 3; v < 256; v += 17) begin
         t_req(8'(v), 1'b1, "R10 level req");
         t_ack("R10 level ack");
         t_eoi("R10 level eoi");
      end

      // R12: suppression
      t_ctl(10'h3F7);
      t_req(8'h44, 1'b1, "R12 req");
      t_ack("R12 ack");
      t_eoi("R12 suppressed");
      t_ctl(10'h1F7);

      // R11: trigger bit follows the latest request
      t_req(8'h50, 1'b1, "R11 level");
      t_ack("R11 ack");
      t_eoi("R11 bcast");
      t_req(8'h50, 1'b0, "R11 edge");
      t_ack("R11 ack");
      t_eoi("R11 silent");

      // R9: nesting, only the highest in-service bit retires
      t_req(8'h20, 1'b1, "R9 nest");
      t_ack("R9 nest ack");
      t_req(8'h90, 1'b0, "R9 nest");
      t_ack("R9 nest ack");
      t_eoi("R9 inner");
      t_eoi("R9 outer");
      t_eoi("R9 empty eoi");

      finish_run();
   end
endmodule